// File: doc/BRIEF.md
# Tag-Matched Reservation Station Array

This block holds operations waiting to run on an adder unit and a multiplier unit. The issue side hands it one operation per cycle. Each source operand is either a ready value or the tag of the station that will produce it. The block places the operation in a free station of the right group. Stations whose operands are missing watch one shared result bus and take a value when the tag on the bus equals the tag they wait for. A station starts counting its fixed latency once both operands are present. When the count ends it asks for the bus, and it sends the result together with its own tag.

The arithmetic is a simple integer stand-in for the real units. Only one result goes out per cycle. When several stations are finished at once, the one issued earliest goes first and the others keep their results. A station becomes free in the cycle it broadcasts. The issue side can therefore use the tag returned at issue as the producer tag for later operations.

Top module: `rsv_station_array`

## Requirements
- R1: After reset every station is free, `cdb_valid` is 0, and `iss_ready` is 1 for both groups: the lowest tag is 1 for an add-type operation and 4 for a multiply-type operation.
- R2: Opcodes are 0 add, 1 subtract, 2 multiply, 3 divide. Codes 0 and 1 go to stations with tags 1 to 3 and codes 2 and 3 go to tags 4 and 5. `iss_tag` gives the lowest free tag of the selected group.
- R3: When every station of the selected group is busy, `iss_ready` is 0, `iss_tag` is 0 and a presented operation is dropped: no station is taken and no result for it ever appears on the bus.
- R4: A source tag of 0 means the value field holds the operand. A nonzero source tag names the producing station, and the value field is ignored.
- R5: A station never executes before both operands are present, so no result appears earlier than the latency allows after the last operand arrived.
- R6: With both operands present at issue and the bus free, the result is broadcast exactly latency+1 cycles after the issue cycle. The latency is 2 for add and subtract, 10 for multiply and 40 for divide.
- R7: When the bus carries tag t, every station waiting on t for either operand (or both) captures `cdb_value`. A station that becomes complete this way broadcasts latency+1 cycles after that bus cycle, if the bus is free.
- R8: An operation issued in the same cycle that the bus carries its producer tag takes the bus value at once and does not wait.
- R9: At most one result is broadcast per cycle. Among finished stations the one issued earliest wins, whatever its tag. The others keep their result and send it in later cycles.
- R10: A station is freed in its broadcast cycle and can be given out again in the next cycle. Every issued operation is broadcast exactly once.
- R11: Results are computed on 16 bits: the sum, the difference, the low 16 bits of the product, and the quotient, with a divide by zero giving 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| iss_valid | input | 1 | An operation is presented for issue |
| iss_op | input | 2 | Opcode: 0 add, 1 sub, 2 mul, 3 div |
| iss_j_tag | input | 3 | First operand producer tag, 0 when the value is ready |
| iss_j_val | input | 16 | First operand value |
| iss_k_tag | input | 3 | Second operand producer tag, 0 when the value is ready |
| iss_k_val | input | 16 | Second operand value |
| iss_ready | output | 1 | A station of the group for `iss_op` is free |
| iss_tag | output | 3 | Tag of the station that takes the operation, 0 if none |
| cdb_valid | output | 1 | A result is on the bus |
| cdb_tag | output | 3 | Tag of the station that produced the result |
| cdb_value | output | 16 | Result value |

## Verification
The bench checks that an operation issued just as its producer broadcasts does not miss the value. A design that missed it would leave the station waiting forever on a tag that never returns. It finishes two waiting stations in the same cycle while the older one holds the higher tag. A design that ranks by index would send them in the wrong order. It fills a group and presents one more operation, which a design without a proper stall would overwrite or duplicate on the bus. It reuses a station in the cycle after it was freed, and it checks exact latencies of add, multiply and divide as well as a divide by zero. Random traffic with chains of dependences is compared against a model that tracks every tag.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } rs_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EXEC = 2'd2,
    ST_DONE = 2'd3
  } rs_state_e;
endpackage

// File: rtl/rsv_entry.sv
module rsv_entry
  import rsv_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int TAG_W   = 3,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  rs_op_e            op_i,
  input  logic [TAG_W-1:0]  qj_i,
  input  logic [DATA_W-1:0] vj_i,
  input  logic [TAG_W-1:0]  qk_i,
  input  logic [DATA_W-1:0] vk_i,
  input  logic              bus_valid_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic [DATA_W-1:0] bus_value_i,
  input  logic              grant_i,
  output logic              busy_o,
  output logic              req_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int CNT_W = $clog2(LAT_DIV + 1);

  rs_state_e         st_q, st_n;
  rs_op_e            op_q, op_n;
  logic [TAG_W-1:0]  qj_q, qj_n, qk_q, qk_n;
  logic [DATA_W-1:0] vj_q, vj_n, vk_q, vk_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] res_q, res_c;
  logic              hit_j, hit_k, opnd_en, res_en;

  function automatic logic [CNT_W-1:0] lat_of(rs_op_e op);
    case (op)
      OP_ADD, OP_SUB: lat_of = CNT_W'(LAT_ADD);
      OP_MUL:         lat_of = CNT_W'(LAT_MUL);
      default:        lat_of = CNT_W'(LAT_DIV);
    endcase
  endfunction

  assign hit_j = bus_valid_i && (qj_q != '0) && (qj_q == bus_tag_i);
  assign hit_k = bus_valid_i && (qk_q != '0) && (qk_q == bus_tag_i);

  // next-state
  always_comb begin
    st_n  = st_q;
    op_n  = op_q;
    qj_n  = qj_q;
    qk_n  = qk_q;
    vj_n  = vj_q;
    vk_n  = vk_q;
    cnt_n = cnt_q;
    case (st_q)
      ST_IDLE: begin
        if (alloc_i) begin
          op_n = op_i;
          if (qj_i != '0 && bus_valid_i && bus_tag_i == qj_i) begin
            qj_n = '0;
            vj_n = bus_value_i;
          end else begin
            qj_n = qj_i;
            vj_n = vj_i;
          end
          if (qk_i != '0 && bus_valid_i && bus_tag_i == qk_i) begin
            qk_n = '0;
            vk_n = bus_value_i;
          end else begin
            qk_n = qk_i;
            vk_n = vk_i;
          end
          st_n  = (qj_n == '0 && qk_n == '0) ? ST_EXEC : ST_WAIT;
          cnt_n = lat_of(op_i);
        end
      end
      ST_WAIT: begin
        if (hit_j) begin
          qj_n = '0;
          vj_n = bus_value_i;
        end
        if (hit_k) begin
          qk_n = '0;
          vk_n = bus_value_i;
        end
        if (qj_n == '0 && qk_n == '0) begin
          st_n  = ST_EXEC;
          cnt_n = lat_of(op_q);
        end
      end
      ST_EXEC: begin
        if (cnt_q == CNT_W'(1)) st_n = ST_DONE;
        else                    cnt_n = cnt_q - CNT_W'(1);
      end
      default: begin
        if (grant_i) st_n = ST_IDLE;
      end
    endcase
  end

  always_comb begin
    case (op_q)
      OP_ADD:  res_c = vj_q + vk_q;
      OP_SUB:  res_c = vj_q - vk_q;
      OP_MUL:  res_c = vj_q * vk_q;
      default: res_c = (vk_q == '0) ? '1 : vj_q / vk_q;
    endcase
  end

  assign opnd_en = alloc_i || (st_q == ST_WAIT);
  assign res_en  = (st_q == ST_EXEC) && (cnt_q == CNT_W'(1));

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      op_q  <= OP_ADD;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      op_q  <= op_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qj_q <= '0;
      qk_q <= '0;
      vj_q <= '0;
      vk_q <= '0;
    end else if (opnd_en) begin
      qj_q <= qj_n;
      qk_q <= qk_n;
      vj_q <= vj_n;
      vk_q <= vk_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_c;
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign req_o    = (st_q == ST_DONE);
  assign result_o = res_q;

  // an operand still owed by a producer keeps the station out of execution
  assert_wait_missing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && qj_i != '0 && !(bus_valid_i && bus_tag_i == qj_i)) |=> (st_q == ST_WAIT));

  assert_capture_j_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && hit_j) |=> (qj_q == '0 && vj_q == $past(bus_value_i)));

  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !grant_i) |=> (req_o && $stable(result_o)));

  assert_free_on_send_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |=> !busy_o);
endmodule

// File: rtl/rsv_age_arb.sv
module rsv_age_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc_i,
  input  logic [N-1:0] busy_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  // older_q[i][j] set: station i was issued before station j
  logic [N-1:0][N-1:0] older_q, older_n;

  always_comb begin
    older_n = older_q;
    for (int k = 0; k < N; k++) begin
      if (alloc_i[k]) begin
        for (int i = 0; i < N; i++) begin
          if (i != k) begin
            older_n[i][k] = busy_i[i];
            older_n[k][i] = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) older_q <= '0;
    else        older_q <= older_n;
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      grant_o[i] = req_i[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && req_i[j] && older_q[j][i]) grant_o[i] = 1'b0;
      end
    end
  end

  assert_single_winner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  assert_bus_not_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != '0) |-> (grant_o != '0));
endmodule

// File: rtl/rsv_station_array.sv
module rsv_station_array
  import rsv_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int N_ADD   = 3,
  parameter int N_MUL   = 2,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 iss_valid,
  input  logic [1:0]                           iss_op,
  input  logic [$clog2(N_ADD+N_MUL+1)-1:0]     iss_j_tag,
  input  logic [DATA_W-1:0]                    iss_j_val,
  input  logic [$clog2(N_ADD+N_MUL+1)-1:0]     iss_k_tag,
  input  logic [DATA_W-1:0]                    iss_k_val,
  output logic                                 iss_ready,
  output logic [$clog2(N_ADD+N_MUL+1)-1:0]     iss_tag,
  output logic                                 cdb_valid,
  output logic [$clog2(N_ADD+N_MUL+1)-1:0]     cdb_tag,
  output logic [DATA_W-1:0]                    cdb_value
);
  localparam int N     = N_ADD + N_MUL;
  localparam int TAG_W = $clog2(N + 1);

  logic [1:0]              rst_pipe_q;
  logic                    rst_int_n;
  logic [N-1:0]            busy, req, grant, alloc;
  logic [N-1:0][DATA_W-1:0] res_vec;
  logic                    want_mul;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // station selection: lowest free tag in the group the opcode belongs to
  assign want_mul = iss_op[1];

  always_comb begin
    iss_ready = 1'b0;
    iss_tag   = '0;
    alloc     = '0;
    for (int i = 0; i < N; i++) begin
      if (!iss_ready && ((i >= N_ADD) == want_mul) && !busy[i]) begin
        iss_ready = 1'b1;
        iss_tag   = TAG_W'(i + 1);
        alloc[i]  = iss_valid;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_station
    rsv_entry #(
      .DATA_W (DATA_W),
      .TAG_W  (TAG_W),
      .LAT_ADD(LAT_ADD),
      .LAT_MUL(LAT_MUL),
      .LAT_DIV(LAT_DIV)
    ) u_entry (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .alloc_i    (alloc[g]),
      .op_i       (rs_op_e'(iss_op)),
      .qj_i       (iss_j_tag),
      .vj_i       (iss_j_val),
      .qk_i       (iss_k_tag),
      .vk_i       (iss_k_val),
      .bus_valid_i(cdb_valid),
      .bus_tag_i  (cdb_tag),
      .bus_value_i(cdb_value),
      .grant_i    (grant[g]),
      .busy_o     (busy[g]),
      .req_o      (req[g]),
      .result_o   (res_vec[g])
    );
  end

  rsv_age_arb #(.N(N)) u_arb (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .alloc_i(alloc),
    .busy_i (busy),
    .req_i  (req),
    .grant_o(grant)
  );

  // shared result bus
  always_comb begin
    cdb_valid = |grant;
    cdb_tag   = '0;
    cdb_value = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) begin
        cdb_tag   = TAG_W'(i + 1);
        cdb_value = res_vec[i];
      end
    end
  end

  assert_stall_no_take_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (iss_valid && !iss_ready) |=> ((busy & ~$past(busy)) == '0));

  assert_take_free_only_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (alloc & busy) == '0);
endmodule

// File: tb/rsv_station_array_tb.sv
`timescale 1ns/1ps
module rsv_station_array_tb_top;
  localparam int LA = 2, LM = 10, LD = 40;
  localparam int NEVER = 1000000000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid;
  logic [1:0]  iss_op;
  logic [2:0]  iss_j_tag, iss_k_tag;
  logic [15:0] iss_j_val, iss_k_val;
  logic        iss_ready;
  logic [2:0]  iss_tag;
  logic        cdb_valid;
  logic [2:0]  cdb_tag;
  logic [15:0] cdb_value;

  always #2 clk = ~clk;

  rsv_station_array dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_j_tag(iss_j_tag), .iss_j_val(iss_j_val), .iss_k_tag(iss_k_tag),
    .iss_k_val(iss_k_val), .iss_ready(iss_ready), .iss_tag(iss_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value)
  );

  int checks = 0, fails = 0, cyc = 0, bc_count = 0;
  bit finished = 0;
  bit m_pend[8];
  int m_op[8], m_jt[8], m_kt[8], m_iss[8], m_bc[8], m_rc[8];
  bit m_jk[8], m_kk[8];
  logic [15:0] m_jv[8], m_kv[8];
  bit acc;
  int acc_tag;

  task automatic chk(bit ok, string rq, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] calc(int op, logic [15:0] a, logic [15:0] b);
    case (op)
      0: calc = a + b;
      1: calc = a - b;
      2: calc = a * b;
      default: calc = (b == 16'd0) ? 16'hFFFF : a / b;
    endcase
  endfunction

  function automatic int lat(int op);
    return (op < 2) ? LA : ((op == 2) ? LM : LD);
  endfunction

  // sample outputs of the current cycle and advance the model
  task automatic obs();
    int exp_tag, lo, hi, t;
    cyc++;
    acc = 0;
    if (iss_valid) begin
      lo = iss_op[1] ? 4 : 1;
      hi = iss_op[1] ? 5 : 3;
      exp_tag = 0;
      for (int u = lo; u <= hi; u++) if (!m_pend[u] && exp_tag == 0) exp_tag = u;
      chk(iss_ready == (exp_tag != 0), "R3", iss_ready, exp_tag != 0);
      if (exp_tag != 0) chk(iss_tag == exp_tag, "R2", iss_tag, exp_tag);
    end
    if (cdb_valid) begin
      t = cdb_tag;
      chk(m_pend[t], "R10", 0, 1);
      chk(cdb_value == calc(m_op[t], m_jv[t], m_kv[t]), "R11", cdb_value,
          calc(m_op[t], m_jv[t], m_kv[t]));
      chk(m_rc[t] != NEVER && cyc >= m_rc[t] + lat(m_op[t]) + 1, "R5,R6",
          cyc, m_rc[t] + lat(m_op[t]) + 1);
      m_pend[t] = 0;
      m_bc[t] = cyc;
      bc_count++;
      for (int u = 1; u <= 5; u++) begin
        if (m_pend[u]) begin
          bit was = m_jk[u] && m_kk[u];
          if (!m_jk[u] && m_jt[u] == t) begin m_jk[u] = 1; m_jv[u] = cdb_value; end
          if (!m_kk[u] && m_kt[u] == t) begin m_kk[u] = 1; m_kv[u] = cdb_value; end
          if (!was && m_jk[u] && m_kk[u]) m_rc[u] = cyc;
        end
      end
    end
    if (iss_valid && iss_ready) begin
      t = iss_tag;
      acc = 1;
      acc_tag = t;
      m_pend[t] = 1;
      m_op[t] = iss_op;
      m_iss[t] = cyc;
      m_jt[t] = iss_j_tag;
      m_kt[t] = iss_k_tag;
      // R4: tag 0 takes the value, a live producer tag is waited on
      m_jk[t] = (iss_j_tag == 0) || (cdb_valid && cdb_tag == iss_j_tag);
      m_jv[t] = (iss_j_tag == 0) ? iss_j_val : cdb_value;
      m_kk[t] = (iss_k_tag == 0) || (cdb_valid && cdb_tag == iss_k_tag);
      m_kv[t] = (iss_k_tag == 0) ? iss_k_val : cdb_value;
      m_rc[t] = (m_jk[t] && m_kk[t]) ? cyc : NEVER;
    end
  endtask

  task automatic tick(bit v, int op, int jt, int jv, int kt, int kv);
    @(negedge clk);
    iss_valid = v;
    iss_op = op[1:0];
    iss_j_tag = jt[2:0];
    iss_j_val = jv[15:0];
    iss_k_tag = kt[2:0];
    iss_k_val = kv[15:0];
    #1;
    obs();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0);
  endtask

  function automatic int pend_count();
    int c = 0;
    for (int u = 1; u <= 5; u++) if (m_pend[u]) c++;
    return c;
  endfunction

  initial begin
    int ta, ts, tm, td, tb, tp, base, n, pick, jt, kt;
    int list[5];
    void'($urandom(32'h5EED_1234));
    rst_n = 0;
    iss_valid = 0; iss_op = 0; iss_j_tag = 0; iss_k_tag = 0; iss_j_val = 0; iss_k_val = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    iss_op = 2'd0; #1;
    chk(cdb_valid == 0, "R1", cdb_valid, 0);
    chk(iss_ready == 1 && iss_tag == 1, "R1", iss_tag, 1);
    iss_op = 2'd2; #1;
    chk(iss_ready == 1 && iss_tag == 4, "R1", iss_tag, 4);

    // R6 R11 exact latencies, divide by zero
    tick(1, 0, 0, 10, 0, 3);   ta = acc_tag;
    tick(1, 1, 0, 10, 0, 30);  ts = acc_tag;
    tick(1, 2, 0, 300, 0, 301); tm = acc_tag;
    tick(1, 3, 0, 77, 0, 0);   td = acc_tag;
    idle(45);
    chk(m_bc[ta] - m_iss[ta] == LA + 1, "R6", m_bc[ta] - m_iss[ta], LA + 1);
    chk(m_bc[ts] - m_iss[ts] == LA + 1, "R6", m_bc[ts] - m_iss[ts], LA + 1);
    chk(m_bc[tm] - m_iss[tm] == LM + 1, "R6", m_bc[tm] - m_iss[tm], LM + 1);
    chk(m_bc[td] - m_iss[td] == LD + 1, "R6", m_bc[td] - m_iss[td], LD + 1);

    // R7 R9 R3: three adds wait on one multiply, then a fourth add is refused
    base = bc_count;
    tick(1, 2, 0, 3, 0, 5); tp = acc_tag;
    tick(1, 0, tp, 0, 0, 1);
    tick(1, 1, 0, 2, tp, 0);
    tick(1, 0, tp, 0, tp, 0);
    tick(1, 0, 0, 9, 0, 9);
    chk(!acc, "R3", acc, 0);
    idle(20);
    chk(bc_count - base == 4, "R3", bc_count - base, 4);
    chk(m_bc[1] == m_bc[tp] + LA + 1, "R7", m_bc[1] - m_bc[tp], LA + 1);
    chk(m_bc[2] == m_bc[tp] + LA + 2, "R9", m_bc[2] - m_bc[tp], LA + 2);
    chk(m_bc[3] == m_bc[tp] + LA + 3, "R9", m_bc[3] - m_bc[tp], LA + 3);

    // R9 R10: older station holds the higher tag
    tick(1, 0, 0, 1, 0, 1);
    tick(1, 2, 0, 4, 0, 4); tp = acc_tag;
    tick(1, 0, tp, 0, 0, 100); tb = acc_tag;
    idle(1);
    tick(1, 1, tp, 0, 0, 6);
    chk(acc && acc_tag == 1, "R10", acc_tag, 1);
    idle(20);
    chk(m_bc[tb] == m_bc[tp] + LA + 1, "R9", m_bc[tb] - m_bc[tp], LA + 1);
    chk(m_bc[1] == m_bc[tp] + LA + 2, "R9", m_bc[1] - m_bc[tp], LA + 2);

    // R8: issue in the producer's broadcast cycle
    tick(1, 2, 0, 12, 0, 12); tp = acc_tag; base = cyc;
    while (cyc < base + LM) idle(1);
    tick(1, 0, tp, 0, 0, 5); tb = acc_tag;
    idle(6);
    chk(m_bc[tp] == base + LM + 1, "R8", m_bc[tp] - base, LM + 1);
    chk(m_bc[tb] == m_bc[tp] + LA + 1, "R8", m_bc[tb] - m_bc[tp], LA + 1);

    // random traffic with dependences
    for (int i = 0; i < 600; i++) begin
      n = 0;
      for (int u = 1; u <= 5; u++) if (m_pend[u]) begin list[n] = u; n++; end
      jt = 0; kt = 0;
      if (n > 0 && ($urandom % 2) == 0) begin pick = $urandom % n; jt = list[pick]; end
      if (n > 0 && ($urandom % 3) == 0) begin pick = $urandom % n; kt = list[pick]; end
      tick(($urandom % 10) < 6, $urandom % 4, jt, $urandom % 65536, kt,
           (($urandom % 8) == 0) ? 0 : $urandom % 65536);
    end
    n = 0;
    while (pend_count() != 0 && n < 3000) begin idle(1); n++; end
    idle(2);
    chk(pend_count() == 0, "R10", pend_count(), 0);
    chk(cdb_valid == 0, "R10", cdb_valid, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule